// File: doc/BRIEF.md
# Mask-Protected GPIO Control Bank

This block is the register bank and pad-side logic for a set of general-purpose pins. Each control function (output enable, output value, input invert, output invert, open drain, and a GPIO-versus-IO-processor owner bit) is held in 32-bit words. The upper half of each word is a per-bit write-enable mask, so software changes one pin with a single write and no read-modify-write. A separate group of plain 32-bit words holds a per-pin source select that steers the pad either to an external pin-multiplex crossbar or to the GPIO/IO-processor path.

For every pin the bank picks the output and enable from one of three sources: the crossbar inputs, its own GPIO registers, or the IO-processor inputs. It then applies output inversion and, if configured, open-drain behaviour, and registers the pad output and pad enable. Pad inputs are inverted per pin. They are registered towards the core and can be read back through the register port.

Access is a simple synchronous port. A write takes effect at the clock edge where `wr_en` is high. Read data is registered and valid on the cycle after `rd_en`.

Top module: `gpio_mask_bank`

## Requirements
- R1: After synchronous reset every register reads 0, and with the crossbar enables low every pad enable is 0.
- R2: A write to a masked group changes control bit b of the addressed word only when wdata bit 16+b is 1; all other control bits keep their value.
- R3: The address is {group[2:0], index}. Group codes are: 0 source-select, 1 owner, 2 output enable, 3 output value, 4 input invert, 5 output invert, 6 open drain, 7 input value. In groups 1 to 6, pin n is bit n%16 of index n/16.
- R4: The source-select group takes plain 32-bit writes with no mask, with pin n at bit n%32 of index n/32, and reads back all 32 bits.
- R5: A source-select bit of 0 routes the crossbar output and enable of that pin to the pad path.
- R6: A source-select bit of 1 with owner bit 1 routes the output-value and output-enable registers. With owner bit 0 it routes the IO-processor output and enable.
- R7: An output-invert bit of 1 inverts the selected output value before the open-drain stage.
- R8: With the open-drain bit at 1 the pad output is 0, and the pad enable is high only when the selected enable is high and the inverted output is 0.
- R9: The core input equals the pad input XOR the input-invert bit. Group 7 reads that value with pin n at bit n%32 of index n/32.
- R10: Reads of groups 1 to 6 return 0 in bits 31:16 and the control bits in bits 15:0.
- R11: Writes to group 7 and to source-select indices at or above pins/32 change nothing, and those source-select indices read as 0.
- R12: Read data appears on the cycle after `rd_en`. Pad output, pad enable and core input update on the clock edge after the register or input that feeds them changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3+log2(2*NUM_PINS/DATA_W) | Group code and word index |
| wdata | input | DATA_W | Write data (mask in upper half for groups 1 to 6) |
| rdata | output | DATA_W | Registered read data |
| fpm_out | input | NUM_PINS | Crossbar output value per pin |
| fpm_oe | input | NUM_PINS | Crossbar output enable per pin |
| iop_out | input | NUM_PINS | IO-processor output value per pin |
| iop_oe | input | NUM_PINS | IO-processor output enable per pin |
| pad_in | input | NUM_PINS | Pad input level per pin |
| pad_out | output | NUM_PINS | Registered pad output value |
| pad_oe | output | NUM_PINS | Registered pad drive enable |
| core_in | output | NUM_PINS | Registered, inversion-corrected pad input |

## Verification
A wrong mask decode or word/bit mapping corrupts a neighbouring pin's control bit. The bench catches this two cycles after the faulty write, on that pin's `pad_out` or `pad_oe`, and later in a full readback. A source-select, owner, inversion or open-drain fault shows on the very next registered pad sample for the pin under test. The sweep visits every pin in all 64 combinations of those bits, with random crossbar, IO-processor and pad inputs. Read-path faults show in `rdata` one cycle after the read strobe, including non-zero upper halves and writes that were meant to be ignored.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int GRP_W = 3;

  typedef enum logic [GRP_W-1:0] {
    GRP_FIRST  = 3'd0,
    GRP_MASTER = 3'd1,
    GRP_OE     = 3'd2,
    GRP_OUT    = 3'd3,
    GRP_IINV   = 3'd4,
    GRP_OINV   = 3'd5,
    GRP_OD     = 3'd6,
    GRP_INPUT  = 3'd7
  } grp_e;

  localparam int MASKED_LO = 1;
  localparam int MASKED_HI = 6;
endpackage

// File: rtl/masked_ctrl_group.sv
module masked_ctrl_group #(
  parameter int NUM_PINS = 128,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] bits
);
  localparam int CTRL_W = DATA_W / 2;
  localparam int MWORDS = NUM_PINS / CTRL_W;

  logic [CTRL_W-1:0] word_q [MWORDS];
  logic [CTRL_W-1:0] wmask;
  logic [CTRL_W-1:0] wval;

  assign wmask = wdata[DATA_W-1 -: CTRL_W];
  assign wval  = wdata[CTRL_W-1:0];

  for (genvar w = 0; w < MWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[w] <= '0;
      end else if (wr_en && (idx == IDX_W'(w))) begin
        word_q[w] <= (word_q[w] & ~wmask) | (wval & wmask);
      end
    end
    assign bits[w*CTRL_W +: CTRL_W] = word_q[w];
  end
endmodule

// File: rtl/first_sel_regs.sv
module first_sel_regs #(
  parameter int NUM_PINS = 128,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] bits
);
  localparam int PWORDS = NUM_PINS / DATA_W;

  logic [DATA_W-1:0] word_q [PWORDS];

  for (genvar w = 0; w < PWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[w] <= '0;
      end else if (wr_en && (idx == IDX_W'(w))) begin
        word_q[w] <= wdata;
      end
    end
    assign bits[w*DATA_W +: DATA_W] = word_q[w];
  end
endmodule

// File: rtl/pad_drive.sv
module pad_drive #(
  parameter int NUM_PINS = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] first_bits,
  input  logic [NUM_PINS-1:0] master_bits,
  input  logic [NUM_PINS-1:0] oe_bits,
  input  logic [NUM_PINS-1:0] out_bits,
  input  logic [NUM_PINS-1:0] iinv_bits,
  input  logic [NUM_PINS-1:0] oinv_bits,
  input  logic [NUM_PINS-1:0] od_bits,
  input  logic [NUM_PINS-1:0] fpm_out,
  input  logic [NUM_PINS-1:0] fpm_oe,
  input  logic [NUM_PINS-1:0] iop_out,
  input  logic [NUM_PINS-1:0] iop_oe,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] core_in
);
  logic [NUM_PINS-1:0] nxt_out;
  logic [NUM_PINS-1:0] nxt_oe;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic src_o;
    logic src_e;
    logic eff;
    always_comb begin
      if (!first_bits[p]) begin
        src_o = fpm_out[p];
        src_e = fpm_oe[p];
      end else if (master_bits[p]) begin
        src_o = out_bits[p];
        src_e = oe_bits[p];
      end else begin
        src_o = iop_out[p];
        src_e = iop_oe[p];
      end
      eff = src_o ^ oinv_bits[p];
      if (od_bits[p]) begin
        nxt_out[p] = 1'b0;
        nxt_oe[p]  = src_e & ~eff;
      end else begin
        nxt_out[p] = eff;
        nxt_oe[p]  = src_e;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      core_in <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
      core_in <= pad_in ^ iinv_bits;
    end
  end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(2 * NUM_PINS / DATA_W),
  localparam int ADDR_W  = GRP_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] fpm_out,
  input  logic [NUM_PINS-1:0] fpm_oe,
  input  logic [NUM_PINS-1:0] iop_out,
  input  logic [NUM_PINS-1:0] iop_oe,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] core_in
);
  localparam int CTRL_W = DATA_W / 2;

  logic [GRP_W-1:0]      grp;
  logic [IDX_W-1:0]      idx;
  logic [NUM_PINS-1:0]   ctrl_bits [0:7];
  logic [NUM_PINS-1:0]   first_bits;
  logic [NUM_PINS-1:0]   master_bits;
  logic [NUM_PINS-1:0]   oe_bits;
  logic [NUM_PINS-1:0]   out_bits;
  logic [NUM_PINS-1:0]   iinv_bits;
  logic [NUM_PINS-1:0]   oinv_bits;
  logic [NUM_PINS-1:0]   od_bits;
  logic [2*NUM_PINS-1:0] first_pad;
  logic [2*NUM_PINS-1:0] in_pad;
  logic [NUM_PINS-1:0]   sel_ctrl;
  logic [DATA_W-1:0]     rd_mux;

  assign grp = addr[ADDR_W-1 -: GRP_W];
  assign idx = addr[IDX_W-1:0];

  first_sel_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_first (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en && (grp == GRP_FIRST)),
    .idx   (idx),
    .wdata (wdata),
    .bits  (first_bits)
  );

  assign ctrl_bits[0] = '0;
  assign ctrl_bits[7] = '0;
  for (genvar g = MASKED_LO; g <= MASKED_HI; g++) begin : g_grp
    masked_ctrl_group #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_grp (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_en && (grp == GRP_W'(g))),
      .idx   (idx),
      .wdata (wdata),
      .bits  (ctrl_bits[g])
    );
  end

  assign master_bits = ctrl_bits[int'(GRP_MASTER)];
  assign oe_bits     = ctrl_bits[int'(GRP_OE)];
  assign out_bits    = ctrl_bits[int'(GRP_OUT)];
  assign iinv_bits   = ctrl_bits[int'(GRP_IINV)];
  assign oinv_bits   = ctrl_bits[int'(GRP_OINV)];
  assign od_bits     = ctrl_bits[int'(GRP_OD)];

  pad_drive #(.NUM_PINS(NUM_PINS)) u_pad (
    .clk         (clk),
    .rst         (rst),
    .first_bits  (first_bits),
    .master_bits (master_bits),
    .oe_bits     (oe_bits),
    .out_bits    (out_bits),
    .iinv_bits   (iinv_bits),
    .oinv_bits   (oinv_bits),
    .od_bits     (od_bits),
    .fpm_out     (fpm_out),
    .fpm_oe      (fpm_oe),
    .iop_out     (iop_out),
    .iop_oe      (iop_oe),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .core_in     (core_in)
  );

  // Zero-extended views keep every indexed slice inside the vector.
  assign first_pad = {{NUM_PINS{1'b0}}, first_bits};
  assign in_pad    = {{NUM_PINS{1'b0}}, pad_in ^ iinv_bits};
  assign sel_ctrl  = ctrl_bits[grp];

  always_comb begin
    case (grp)
      GRP_FIRST: rd_mux = first_pad[DATA_W*idx +: DATA_W];
      GRP_INPUT: rd_mux = in_pad[DATA_W*idx +: DATA_W];
      default:   rd_mux = {{CTRL_W{1'b0}}, sel_ctrl[CTRL_W*idx +: CTRL_W]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_mask_bank_chk.sv
module gpio_mask_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   rdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] first_bits,
  input logic [NUM_PINS-1:0] master_bits,
  input logic [NUM_PINS-1:0] oe_bits,
  input logic [NUM_PINS-1:0] od_bits
);
  logic [GRP_W-1:0] grp;
  assign grp = addr[ADDR_W-1 -: GRP_W];

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && ($past(grp) != GRP_FIRST) && ($past(grp) != GRP_INPUT))
      |-> (rdata[DATA_W-1 -: DATA_W/2] == '0));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(oe_bits));

  assert_first_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(first_bits));

  assert_od_low_R8: assert property (@(posedge clk) disable iff (rst)
    ((pad_out & $past(od_bits)) == '0));

  assert_gpio_oe_R6: assert property (@(posedge clk) disable iff (rst)
    (((pad_oe ^ $past(oe_bits)) & $past(first_bits & master_bits & ~od_bits)) == '0));
endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .rdata       (rdata),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .first_bits  (first_bits),
  .master_bits (master_bits),
  .oe_bits     (oe_bits),
  .od_bits     (od_bits)
);

// File: tb/gpio_mask_bank_bench.sv
module gpio_mask_bank_bench;
  localparam int NP = 32;
  localparam int IW = 1;
  localparam int AW = 3 + IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] fpm_out = '0, fpm_oe = '0, iop_out = '0, iop_oe = '0, pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, core_in;

  logic [NP-1:0] m_first = '0, m_master = '0, m_oe = '0, m_out = '0;
  logic [NP-1:0] m_iinv = '0, m_oinv = '0, m_od = '0;
  logic [31:0]   rs = 32'h1234_5679;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5ns clk = ~clk;

  gpio_mask_bank #(.NUM_PINS(NP), .DATA_W(32)) u_gpio_mask_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fpm_out(fpm_out), .fpm_oe(fpm_oe),
    .iop_out(iop_out), .iop_oe(iop_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic model_write(input int g, input int ix, input logic [31:0] d);
    if (g == 0) begin
      if (ix < NP / 32) m_first[ix*32 +: 32] = d;
    end else if (g >= 1 && g <= 6) begin
      for (int b = 0; b < 16; b++) begin
        if (d[16+b]) begin
          case (g)
            1: m_master[ix*16+b] = d[b];
            2: m_oe[ix*16+b]     = d[b];
            3: m_out[ix*16+b]    = d[b];
            4: m_iinv[ix*16+b]   = d[b];
            5: m_oinv[ix*16+b]   = d[b];
            default: m_od[ix*16+b] = d[b];
          endcase
        end
      end
    end
  endtask

  function automatic logic [31:0] model_read(input int g, input int ix);
    logic [NP-1:0] v;
    case (g)
      0: return (ix < NP / 32) ? m_first[ix*32 +: 32] : 32'h0;
      7: begin
        v = pad_in ^ m_iinv;
        return (ix < NP / 32) ? v[ix*32 +: 32] : 32'h0;
      end
      1: v = m_master;
      2: v = m_oe;
      3: v = m_out;
      4: v = m_iinv;
      5: v = m_oinv;
      default: v = m_od;
    endcase
    return {16'h0, v[ix*16 +: 16]};
  endfunction

  task automatic do_write(input int g, input int ix, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = {3'(g), IW'(ix)};
    wdata = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    model_write(g, ix, d);
  endtask

  task automatic do_read(input int g, input int ix, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    addr  = {3'(g), IW'(ix)};
    @(posedge clk);
    #1;
    rd_en = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic check_pads(input string tag_out);
    logic [NP-1:0] e_out, e_oe;
    logic so, se, ef;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      if (m_first[i] == 1'b0) begin so = fpm_out[i]; se = fpm_oe[i]; end
      else if (m_master[i])   begin so = m_out[i];   se = m_oe[i];   end
      else                    begin so = iop_out[i]; se = iop_oe[i]; end
      ef = m_oinv[i] ? !so : so;
      if (m_od[i]) begin
        e_out[i] = 1'b0;
        e_oe[i]  = se && !ef;
      end else begin
        e_out[i] = ef;
        e_oe[i]  = se;
      end
    end
    check({tag_out, " pad_out"}, pad_out, e_out);
    check({tag_out, " pad_oe"}, pad_oe, e_oe);
    check("R9 core_in", core_in, pad_in ^ m_iinv);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] d;
    string tag;

    fpm_out = 32'hA5C3_0F96;
    pad_in  = 32'h3C3C_5A5A;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    for (int g = 0; g < 7; g++) begin
      do_read(g, 0, rd);
      check("R1 reset register", rd, 32'h0);
    end
    check("R1 reset pad_oe", pad_oe, 32'h0);
    check("R5 reset crossbar route", pad_out, fpm_out);
    do_read(7, 0, rd);
    check("R9 input readback", rd, pad_in);

    // R12 latency: pin 0 as GPIO output high, then invert
    do_write(0, 0, 32'h0000_0001);
    do_write(1, 0, 32'h0001_0001);
    do_write(2, 0, 32'h0001_0001);
    do_write(3, 0, 32'h0001_0001);
    check_pads("R6");
    do_write(5, 0, 32'h0001_0001);
    @(negedge clk);
    check("R12 pad one edge late", 32'(pad_out[0]), 32'h1);
    @(negedge clk);
    check("R7 inverted output", 32'(pad_out[0]), 32'h0);

    // R2 mask-less write changes nothing
    do_write(2, 0, 32'h0000_FFFE);
    do_read(2, 0, rd);
    check("R2 zero mask", rd, model_read(2, 0));
    // R2 partial mask
    do_write(2, 1, 32'h00F0_FFFF);
    do_read(2, 1, rd);
    check("R2 partial mask", rd, 32'h0000_00F0);
    // R10 upper half reads zero
    do_write(6, 1, 32'h0000_0000);
    do_write(4, 1, 32'hFFFF_FFFF);
    do_read(4, 1, rd);
    check("R10 upper zero", rd, 32'h0000_FFFF);
    do_write(4, 1, 32'hFFFF_0000);
    // R4 plain first-level write
    do_write(0, 0, 32'hDEAD_BEEF);
    do_read(0, 0, rd);
    check("R4 plain readback", rd, 32'hDEAD_BEEF);
    // R11 ignored writes
    do_write(0, 1, 32'hFFFF_FFFF);
    do_read(0, 1, rd);
    check("R11 unused index reads 0", rd, 32'h0);
    do_read(0, 0, rd);
    check("R11 unused index no alias", rd, 32'hDEAD_BEEF);
    do_write(7, 0, 32'hFFFF_FFFF);
    do_read(7, 0, rd);
    check("R11 input group write ignored", rd, pad_in ^ m_iinv);
    do_write(0, 0, 32'h0);

    // Sweep: every pin, every combination of six control bits
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 64; c++) begin
        logic [31:0] mk;
        @(negedge clk);
        fpm_out = rnd(); fpm_oe = rnd(); iop_out = rnd(); iop_oe = rnd(); pad_in = rnd();
        d = m_first;
        d[p] = c[0];
        do_write(0, p / 32, d);
        mk = 32'h1 << (16 + p % 16);
        do_write(1, p / 16, mk | (32'(c[1]) << (p % 16)));
        do_write(2, p / 16, mk | (32'(c[2]) << (p % 16)));
        do_write(3, p / 16, mk | (32'(c[3]) << (p % 16)));
        do_write(4, p / 16, mk | (32'(c[1] ^ c[4]) << (p % 16)));
        do_write(5, p / 16, mk | (32'(c[4]) << (p % 16)));
        do_write(6, p / 16, mk | (32'(c[5]) << (p % 16)));
        if (c[5])      tag = "R8";
        else if (c[4]) tag = "R7";
        else if (!c[0]) tag = "R5";
        else           tag = "R6";
        check_pads(tag);
      end
    end

    // R3 full readback of the word/bit mapping after the sweep
    for (int g = 1; g < 7; g++) begin
      for (int ix = 0; ix < 2; ix++) begin
        do_read(g, ix, rd);
        check("R3 word mapping", rd, model_read(g, ix));
      end
    end
    do_read(7, 0, rd);
    check("R9 input readback inverted", rd, model_read(7, 0));

    report();
  end
endmodule